// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Character FIFO

This block takes a single asynchronous serial line, samples it with a sixteen-times oversampling enable and rebuilds each character. It checks the parity and the stop bit, recognises a line break and writes every accepted character into a small receive queue. Each queue entry holds the data byte and its own status bits, so a consumer always sees a character together with the errors that belong to it.

A static configuration selects the character length, the parity rule and whether the queue holds its full depth or half of it. The consumer reads through a simple pop interface. The head entry is visible whenever the queue is not empty, and one pop removes it. Level, empty and full flags show how far the queue has filled. A watchdog output is raised when characters have been waiting unread and the line has delivered nothing new for a long time.

Top module: `uart_rx_fifo`

## Requirements
- R1: Data bits arrive least significant first. A logic high is mark and a logic low is space. `len_sel_i` selects the length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the selected length read as zero on `data_o`.
- R2: `par_mode_i` sets the parity rule. 0 means no parity bit. 1 means even: the data bits and the parity bit together hold an even number of ones. 2 means odd. 3 means the parity bit must equal `par_force_i`. A parity bit that breaks the rule sets `perr_o` on that character.
- R3: The line may go low and then be high again at the middle of the start bit, eight enable ticks after the low level was seen. In that case nothing is stored, and the receiver returns to looking for a new start.
- R4: A character that is not a break and whose stop-bit sample is low is stored with `ferr_o` set.
- R5: A character whose data, parity and stop samples are all low is a break. It is stored once, as data 0 with `brk_o` set and `perr_o` and `ferr_o` clear. Nothing more is stored until the line has returned to mark. A break that begins in the middle of a character gives that character with `ferr_o` set, followed by one break entry.
- R6: With `fifo_half_i` low, the queue holds 16 characters. `level_o` gives the number stored and `full_o` is set at 16.
- R7: With `fifo_half_i` high, the queue holds at most 8 characters, and `full_o` is set at a level of 8.
- R8: A character that completes while the queue is full is dropped. The most recently stored entry then reads with `ovr_o` set. All older entries keep `ovr_o` clear.
- R9: When `empty_o` is low, `data_o` and its status bits show the oldest entry, and `pop_i` removes it. Entries leave in arrival order. A pop while the queue is empty has no effect.
- R10: `wdog_o` rises when the queue is not empty and 64 bit times (1024 enable ticks) have passed with no character stored and no pop. A pop, a new character or an empty queue clears it.
- R11: After reset, `empty_o` is high, `level_o` is 0, and `full_o` and `wdog_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Oversampling enable, sixteen pulses per bit |
| rxd_i | input | 1 | Serial line, idle high |
| len_sel_i | input | 2 | Character length select (5 to 8 bits) |
| par_mode_i | input | 2 | Parity rule: none, even, odd, forced |
| par_force_i | input | 1 | Parity value expected in forced mode |
| fifo_half_i | input | 1 | Limit the queue to half depth |
| pop_i | input | 1 | Remove the head entry |
| data_o | output | 8 | Head entry data |
| perr_o | output | 1 | Head entry parity error |
| ferr_o | output | 1 | Head entry framing error |
| brk_o | output | 1 | Head entry is a break |
| ovr_o | output | 1 | A character was dropped after the head entry |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue at its selected limit |
| level_o | output | 5 | Number of stored entries |
| wdog_o | output | 1 | Unread data has gone stale |

## Verification
The bench uses the default parameters: a depth of 16, sixteen times oversampling and a 64-bit-time watchdog. The enable pulses every second clock. A 16-deep queue lets the bench fill the queue completely in both depth modes and drive it into overrun. With a watchdog of about two thousand clocks, the bench can check the watchdog just before it is due and just after. All four length codes and all four parity rules are used. The line stimuli include a glitch shorter than half a bit, a break held well past one frame, and a break that starts after three data bits.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRKWAIT
  } rx_state_e;

  localparam logic [1:0] PAR_NONE  = 2'd0;
  localparam logic [1:0] PAR_EVEN  = 2'd1;
  localparam logic [1:0] PAR_ODD   = 2'd2;
  localparam logic [1:0] PAR_FORCE = 2'd3;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       brk;
  } rx_char_t;

endpackage

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [1:0] len_sel_i,
  input  logic [1:0] par_mode_i,
  input  logic       par_force_i,
  output logic       push_o,
  output rx_char_t   char_o
);
  localparam int PH_W = $clog2(OSR);
  localparam logic [PH_W-1:0] MID = PH_W'(OSR / 2);

  rx_state_e       st_q;
  logic [PH_W-1:0] ph_q;
  logic [2:0]      idx_q;
  logic [7:0]      sh_q;
  logic            ones_q, par_q;

  logic [2:0] last_idx;
  logic       par_on, exp_par, brk_now;

  assign last_idx = {1'b0, len_sel_i} + 3'd4;
  assign par_on   = (par_mode_i != PAR_NONE);
  assign brk_now  = !ones_q && !par_q && !rxd_i;

  always_comb begin
    case (par_mode_i)
      PAR_EVEN:  exp_par = ^sh_q;
      PAR_ODD:   exp_par = ~^sh_q;
      PAR_FORCE: exp_par = par_force_i;
      default:   exp_par = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      ones_q <= 1'b0;
      par_q  <= 1'b0;
      push_o <= 1'b0;
      char_o <= '0;
    end else begin
      push_o <= 1'b0;
      if (tick_i) begin
        if (st_q == ST_IDLE) begin
          if (!rxd_i) begin
            st_q <= ST_START;
            ph_q <= PH_W'(1);
          end
        end else if (st_q == ST_BRKWAIT) begin
          if (rxd_i) st_q <= ST_IDLE;
        end else begin
          ph_q <= ph_q + 1'b1;
          if (ph_q == MID) begin
            case (st_q)
              ST_START: begin
                if (rxd_i) st_q <= ST_IDLE;  // false start
                else begin
                  st_q   <= ST_DATA;
                  idx_q  <= '0;
                  sh_q   <= '0;
                  ones_q <= 1'b0;
                  par_q  <= 1'b0;
                end
              end
              ST_DATA: begin
                sh_q[idx_q] <= rxd_i;
                ones_q      <= ones_q | rxd_i;
                if (idx_q == last_idx) st_q <= par_on ? ST_PAR : ST_STOP;
                else idx_q <= idx_q + 1'b1;
              end
              ST_PAR: begin
                par_q <= rxd_i;
                st_q  <= ST_STOP;
              end
              ST_STOP: begin
                push_o <= 1'b1;
                if (brk_now) begin
                  char_o.data <= '0;
                  char_o.perr <= 1'b0;
                  char_o.ferr <= 1'b0;
                  char_o.brk  <= 1'b1;
                  st_q        <= ST_BRKWAIT;
                end else begin
                  char_o.data <= sh_q;
                  char_o.perr <= par_on && (par_q != exp_par);
                  char_o.ferr <= !rxd_i;
                  char_o.brk  <= 1'b0;
                  st_q        <= ST_IDLE;
                end
              end
              default: st_q <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  rx_char_t      wchar_i,
  input  logic          pop_i,
  input  logic          half_i,
  output rx_char_t      rchar_o,
  output logic          rovr_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [LW-1:0] level_o
);
  rx_char_t        mem_q [DEPTH];
  logic [DEPTH-1:0] ovr_q;
  logic [AW-1:0]   wptr_q, rptr_q, wlast;
  logic [LW-1:0]   cnt_q, limit;
  logic            do_push, do_drop, do_pop;

  assign limit   = half_i ? LW'(DEPTH / 2) : LW'(DEPTH);
  assign full_o  = (cnt_q >= limit);
  assign empty_o = (cnt_q == '0);
  assign level_o = cnt_q;
  assign do_push = push_i && !full_o;
  assign do_drop = push_i && full_o;
  assign do_pop  = pop_i && !empty_o;
  assign wlast   = wptr_q - 1'b1;
  assign rchar_o = mem_q[rptr_q];
  assign rovr_o  = ovr_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wchar_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) begin
        ovr_q[wptr_q] <= 1'b0;
        wptr_q        <= wptr_q + 1'b1;
      end
      if (do_drop) ovr_q[wlast] <= 1'b1;
      if (do_pop) rptr_q <= rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_stale_timer.sv
module uart_rx_stale_timer #(
  parameter int LIMIT_TICKS = 1024,
  localparam int CW = $clog2(LIMIT_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clear_i,
  output logic fire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fire_o <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      fire_o <= 1'b0;
    end else if (tick_i && !fire_o) begin
      if (cnt_q == CW'(LIMIT_TICKS - 1)) fire_o <= 1'b1;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int OSR       = 16,
  parameter int WDOG_BITS = 64,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick16_i,
  input  logic          rxd_i,
  input  logic [1:0]    len_sel_i,
  input  logic [1:0]    par_mode_i,
  input  logic          par_force_i,
  input  logic          fifo_half_i,
  input  logic          pop_i,
  output logic [7:0]    data_o,
  output logic          perr_o,
  output logic          ferr_o,
  output logic          brk_o,
  output logic          ovr_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [LW-1:0] level_o,
  output logic          wdog_o
);
  logic [1:0] sync_q;
  logic       rxd_s, rx_push, wd_clear;
  rx_char_t   rx_char, head;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end
  assign rxd_s = sync_q[1];

  uart_rx_deframer #(.OSR(OSR)) i_deframer (
    .clk_i, .rst_ni,
    .tick_i      (tick16_i),
    .rxd_i       (rxd_s),
    .len_sel_i, .par_mode_i, .par_force_i,
    .push_o      (rx_push),
    .char_o      (rx_char)
  );

  uart_rx_queue #(.DEPTH(DEPTH)) i_queue (
    .clk_i, .rst_ni,
    .push_i  (rx_push),
    .wchar_i (rx_char),
    .pop_i,
    .half_i  (fifo_half_i),
    .rchar_o (head),
    .rovr_o  (ovr_o),
    .empty_o, .full_o, .level_o
  );

  assign data_o = head.data;
  assign perr_o = head.perr;
  assign ferr_o = head.ferr;
  assign brk_o  = head.brk;

  assign wd_clear = rx_push || pop_i || empty_o;

  uart_rx_stale_timer #(.LIMIT_TICKS(WDOG_BITS * OSR)) i_stale (
    .clk_i, .rst_ni,
    .tick_i  (tick16_i),
    .clear_i (wd_clear),
    .fire_o  (wdog_o)
  );

endmodule

module uart_rx_fifo_chk #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push_i,
  input logic          pop_i,
  input logic          half_i,
  input logic          empty_i,
  input logic          full_i,
  input logic [LW-1:0] level_i,
  input logic [7:0]    data_i,
  input logic          perr_i,
  input logic          ferr_i,
  input logic          brk_i,
  input logic          wdog_i
);
  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= (half_i ? LW'(DEPTH / 2) : LW'(DEPTH))) else $error("level bound"); // R7

  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i && push_i && !pop_i |=> level_i == $past(level_i)) else $error("full drop"); // R8

  AST_POP_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !empty_i && !push_i |=> level_i == $past(level_i) - 1'b1) else $error("pop dec"); // R9

  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_i && pop_i && !push_i |=> empty_i) else $error("empty pop"); // R9

  AST_BRK_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_i && brk_i |-> data_i == 8'd0 && !perr_i && !ferr_i) else $error("brk clean"); // R5

  AST_WD_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_i |-> !wdog_i) else $error("wdog empty"); // R10

endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .push_i  (rx_push),
  .pop_i   (pop_i),
  .half_i  (fifo_half_i),
  .empty_i (empty_o),
  .full_i  (full_o),
  .level_i (level_o),
  .data_i  (data_o),
  .perr_i  (perr_o),
  .ferr_i  (ferr_o),
  .brk_i   (brk_o),
  .wdog_i  (wdog_o)
);

// File: tb/test_uart_rx_fifo.sv
module test_uart_rx_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CYC    = 32;  // 16 ticks, one tick every 2 clocks

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] len_sel = 2'd3;
  logic [1:0] par_mode = 2'd0;
  logic       par_force = 1'b0;
  logic       fifo_half = 1'b0;
  logic       pop = 1'b0;
  logic [7:0] data;
  logic       perr, ferr, brk, ovr, empty, full, wdog;
  logic [4:0] level;

  int n_chk = 0;
  int n_fail = 0;

  uart_rx_fifo i_uart_rx_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .tick16_i(tick), .rxd_i(rxd),
    .len_sel_i(len_sel), .par_mode_i(par_mode), .par_force_i(par_force),
    .fifo_half_i(fifo_half), .pop_i(pop),
    .data_o(data), .perr_o(perr), .ferr_o(ferr), .brk_o(brk), .ovr_o(ovr),
    .empty_o(empty), .full_o(full), .level_o(level), .wdog_o(wdog)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic line_bit(input logic b);
    rxd = b;
    wait_cyc(BIT_CYC);
  endtask

  task automatic send_char(input logic [7:0] d, input int nbits, input logic [1:0] pm,
                           input logic pf, input logic bad_par, input logic stop_v);
    logic p;
    logic [7:0] m;
    m = 8'hFF >> (8 - nbits);
    case (pm)
      2'd1: p = ^(d & m);
      2'd2: p = ~^(d & m);
      default: p = pf;
    endcase
    line_bit(1'b0);
    for (int i = 0; i < nbits; i++) line_bit(d[i]);
    if (pm != 2'd0) line_bit(p ^ bad_par);
    line_bit(stop_v);
    line_bit(1'b1);
  endtask

  task automatic pop_head(input string tag, input logic [7:0] d, input logic pe,
                          input logic fe, input logic bk, input logic ov);
    chk({tag, " nonempty"}, {31'd0, empty}, 32'd0);
    chk({tag, " data"}, {24'd0, data}, {24'd0, d});
    chk({tag, " flags"}, {28'd0, perr, ferr, brk, ovr}, {28'd0, pe, fe, bk, ov});
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 empty", {31'd0, empty}, 32'd1);
    chk("R11 level", {27'd0, level}, 32'd0);
    chk("R11 full/wdog", {30'd0, full, wdog}, 32'd0);
  endtask

  task automatic t_lengths;
    par_mode = 2'd0;
    len_sel = 2'd3; send_char(8'hA5, 8, 2'd0, 1'b0, 1'b0, 1'b1);
    len_sel = 2'd0; send_char(8'hF5, 5, 2'd0, 1'b0, 1'b0, 1'b1);
    len_sel = 2'd1; send_char(8'hEA, 6, 2'd0, 1'b0, 1'b0, 1'b1);
    len_sel = 2'd2; send_char(8'h9C, 7, 2'd0, 1'b0, 1'b0, 1'b1);
    chk("R1 level", {27'd0, level}, 32'd4);
    pop_head("R1 len8", 8'hA5, 0, 0, 0, 0);
    pop_head("R1 len5", 8'h15, 0, 0, 0, 0);
    pop_head("R1 len6", 8'h2A, 0, 0, 0, 0);
    pop_head("R1 len7", 8'h1C, 0, 0, 0, 0);
    len_sel = 2'd3;
  endtask

  task automatic t_parity;
    par_mode = 2'd1; send_char(8'h37, 8, 2'd1, 1'b0, 1'b0, 1'b1);
    send_char(8'h37, 8, 2'd1, 1'b0, 1'b1, 1'b1);
    par_mode = 2'd2; send_char(8'h81, 8, 2'd2, 1'b0, 1'b0, 1'b1);
    send_char(8'h81, 8, 2'd2, 1'b0, 1'b1, 1'b1);
    par_mode = 2'd3; par_force = 1'b1;
    send_char(8'h00, 8, 2'd3, 1'b1, 1'b0, 1'b1);
    send_char(8'h5A, 8, 2'd3, 1'b1, 1'b1, 1'b1);
    pop_head("R2 even ok", 8'h37, 0, 0, 0, 0);
    pop_head("R2 even bad", 8'h37, 1, 0, 0, 0);
    pop_head("R2 odd ok", 8'h81, 0, 0, 0, 0);
    pop_head("R2 odd bad", 8'h81, 1, 0, 0, 0);
    pop_head("R2 force ok", 8'h00, 0, 0, 0, 0);
    pop_head("R2 force bad", 8'h5A, 1, 0, 0, 0);
    par_mode = 2'd0; par_force = 1'b0;
  endtask

  task automatic t_false_start;
    rxd = 1'b0;
    wait_cyc(8);
    rxd = 1'b1;
    wait_cyc(12 * BIT_CYC);
    chk("R3 nothing stored", {27'd0, level}, 32'd0);
    send_char(8'h6C, 8, 2'd0, 1'b0, 1'b0, 1'b1);
    pop_head("R3 recovers", 8'h6C, 0, 0, 0, 0);
  endtask

  task automatic t_framing;
    send_char(8'hC3, 8, 2'd0, 1'b0, 1'b0, 1'b0);
    wait_cyc(2 * BIT_CYC);
    chk("R4 level", {27'd0, level}, 32'd1);
    pop_head("R4 framing", 8'hC3, 0, 1, 0, 0);
  endtask

  task automatic t_break;
    rxd = 1'b0;
    wait_cyc(20 * BIT_CYC);
    chk("R5 single break entry", {27'd0, level}, 32'd1);
    rxd = 1'b1;
    wait_cyc(3 * BIT_CYC);
    chk("R5 level after release", {27'd0, level}, 32'd1);
    pop_head("R5 break", 8'h00, 0, 0, 1, 0);
    send_char(8'h42, 8, 2'd0, 1'b0, 1'b0, 1'b1);
    pop_head("R5 after break", 8'h42, 0, 0, 0, 0);
  endtask

  task automatic t_midbreak;
    line_bit(1'b0);
    line_bit(1'b1); line_bit(1'b1); line_bit(1'b1);
    rxd = 1'b0;
    wait_cyc(20 * BIT_CYC);
    rxd = 1'b1;
    wait_cyc(3 * BIT_CYC);
    chk("R5 mid break level", {27'd0, level}, 32'd2);
    pop_head("R5 mid cut char", 8'h07, 0, 1, 0, 0);
    pop_head("R5 mid break", 8'h00, 0, 0, 1, 0);
  endtask

  task automatic t_fifo16;
    fifo_half = 1'b0;
    for (int i = 0; i < 16; i++) send_char(8'(8'h30 + i), 8, 2'd0, 1'b0, 1'b0, 1'b1);
    chk("R6 level 16", {27'd0, level}, 32'd16);
    chk("R6 full", {31'd0, full}, 32'd1);
    for (int i = 0; i < 16; i++) pop_head("R6 order", 8'(8'h30 + i), 0, 0, 0, 0);
    chk("R9 drained", {31'd0, empty}, 32'd1);
    pop = 1'b1; @(negedge clk); pop = 1'b0; @(negedge clk);
    chk("R9 empty pop level", {27'd0, level}, 32'd0);
    send_char(8'h99, 8, 2'd0, 1'b0, 1'b0, 1'b1);
    pop_head("R9 after empty pop", 8'h99, 0, 0, 0, 0);
  endtask

  task automatic t_fifo8_overrun;
    fifo_half = 1'b1;
    for (int i = 0; i < 9; i++) send_char(8'(8'h50 + i), 8, 2'd0, 1'b0, 1'b0, 1'b1);
    chk("R7 level 8", {27'd0, level}, 32'd8);
    chk("R7 full", {31'd0, full}, 32'd1);
    for (int i = 0; i < 7; i++) pop_head("R8 older clean", 8'(8'h50 + i), 0, 0, 0, 0);
    pop_head("R8 last flagged", 8'h57, 0, 0, 0, 1);
    chk("R8 dropped", {31'd0, empty}, 32'd1);
    fifo_half = 1'b0;
  endtask

  task automatic t_watchdog;
    send_char(8'h11, 8, 2'd0, 1'b0, 1'b0, 1'b1);
    wait_cyc(1900);
    chk("R10 not yet", {31'd0, wdog}, 32'd0);
    wait_cyc(200);
    chk("R10 fired", {31'd0, wdog}, 32'd1);
    pop_head("R10 data", 8'h11, 0, 0, 0, 0);
    chk("R10 cleared", {31'd0, wdog}, 32'd0);
    wait_cyc(2500);
    chk("R10 idle when empty", {31'd0, wdog}, 32'd0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    wait_cyc(3);
    t_reset();
    rst_ni = 1'b1;
    wait_cyc(4);
    t_lengths();
    t_parity();
    t_false_start();
    t_framing();
    t_break();
    t_midbreak();
    t_fifo16();
    t_fifo8_overrun();
    t_watchdog();
    finish_run();
  end

endmodule